// File: doc/BRIEF.md
# Address-Latched Multicart Bank Mapper

This block sits between an 8-bit CPU bus, a video bus and three memories: a program ROM of up to 1 MB, a character ROM and a 2 KB nametable RAM. It keeps one small configuration register. That register is loaded only from the *address* of a CPU write that lands in the upper 32 KB window. The mapper has no data input at all, so whatever byte the CPU writes cannot affect it.

One write address carries every setting at once:
- bits [5:0] give the 8 KB character bank;
- bits [11:6] give a 6-bit program bank number in 16 KB units;
- bit 12 picks a 16 KB mode (set) or a 32 KB mode (clear);
- bit 13 picks horizontal mirroring (set) or vertical mirroring (clear).

From the stored settings the block forms the high bits of the program ROM address for the two 16 KB CPU windows, 0x8000–0xBFFF and 0xC000–0xFFFF. It also forms the character ROM address and folds the video address into the 2 KB nametable RAM. Decoding which video device is selected is done outside the block.

Top module: `addr_latch_mapper`

## Requirements
- R1: The register loads only on a rising clock edge where cpu_cs, cpu_we and cpu_addr[15] are all 1. A read (cpu_we=0), a write below 0x8000, or a cycle with cpu_cs=0 leaves every output mapping unchanged.
- R2: A loading write sets the character bank to cpu_addr[5:0]. chr_rom_addr is then {bank, ppu_addr[12:0]}.
- R3: With write bit 12 = 0 (32 KB mode), the 0x8000 window uses the bank number with bit 0 cleared, and the 0xC000 window uses it with bit 0 set.
- R4: With write bit 12 = 1 (16 KB mode), both windows use the bank number cpu_addr[11:6] unchanged.
- R5: prg_rom_addr is {window bank, cpu_addr[13:0]}. cpu_addr[14] = 0 picks the 0x8000 window and cpu_addr[14] = 1 picks the 0xC000 window.
- R6: mirror_horz takes write bit 13: 1 means horizontal and 0 means vertical.
- R7: nt_ram_addr is {sel, ppu_addr[9:0]}. sel is ppu_addr[10] under vertical mirroring and ppu_addr[11] under horizontal mirroring.
- R8: A synchronous reset (rst_n = 0) points both windows at chunk PRG_CHUNKS−2 (62 by default) and sets the character bank to 0 and the mirroring to vertical.
- R9: A loading write is visible on the outputs from the cycle after its edge. Back-to-back writes each take effect in turn, and the later one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_cs | input | 1 | CPU cycle selects the cartridge |
| cpu_we | input | 1 | CPU cycle is a write |
| cpu_addr | input | 16 | CPU address |
| ppu_addr | input | 13 | Video address, low bits |
| prg_rom_addr | output | 20 | Program ROM byte address |
| chr_rom_addr | output | 19 | Character ROM byte address |
| nt_ram_addr | output | 11 | Nametable RAM address |
| mirror_horz | output | 1 | 1 when horizontal mirroring is active |

## Verification
A CPU lookup and a configuration load can share one cycle. In that cycle cpu_addr is both the write address and the program-window address. The bench provokes this with back-to-back writes and judges the ports at the falling edge between them. At that point the outputs must show the write that was just captured, and nothing from the address still being presented. A full sweep of the 6-bit bank number in both program modes, together with a sweep of the character bank under both mirrorings, checks the arithmetic. Each case is probed in both windows and against the nametable fold.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef enum logic {MIR_VERT = 1'b0, MIR_HORZ = 1'b1} mirror_e;
  localparam int CPU_AW    = 16;
  localparam int WIN_SEL   = 14;
  localparam int GATE_BIT  = 15;
  localparam int NT_PAGE_AW = 10;
endpackage

// File: rtl/mapper_cfg_reg.sv
module mapper_cfg_reg #(
  parameter int PRG_BANK_W = 6,
  parameter int CHR_BANK_W = 6,
  parameter int PRG_CHUNKS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [15:0]           wr_addr,
  output logic [CHR_BANK_W-1:0] chr_bank,
  output logic [PRG_BANK_W-1:0] prg_num,
  output logic                  mode16,
  output mapper_pkg::mirror_e   mirror
);
  localparam int PRG_LSB  = CHR_BANK_W;
  localparam int MODE_BIT = PRG_LSB + PRG_BANK_W;
  localparam int MIR_BIT  = MODE_BIT + 1;
  localparam logic [PRG_BANK_W-1:0] RST_CHUNK = PRG_BANK_W'(PRG_CHUNKS - 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chr_bank <= '0;
      prg_num  <= RST_CHUNK;
      mode16   <= 1'b1;
      mirror   <= mapper_pkg::MIR_VERT;
    end else if (wr_en) begin
      chr_bank <= wr_addr[CHR_BANK_W-1:0];
      prg_num  <= wr_addr[PRG_LSB +: PRG_BANK_W];
      mode16   <= wr_addr[MODE_BIT];
      mirror   <= mapper_pkg::mirror_e'(wr_addr[MIR_BIT]);
    end
  end
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map #(
  parameter int W     = 6,
  parameter int UPPER = 0
) (
  input  logic [W-1:0] num,
  input  logic         mode16,
  output logic [W-1:0] bank
);
  function automatic logic [W-1:0] pick(input logic [W-1:0] n, input logic m16);
    if (m16) return n;
    return {n[W-1:1], 1'(UPPER)};
  endfunction

  assign bank = pick(num, mode16);
endmodule

// File: rtl/chr_nt_map.sv
module chr_nt_map #(
  parameter int CHR_BANK_W = 6,
  parameter int VID_AW     = 13
) (
  input  logic [CHR_BANK_W-1:0]        chr_bank,
  input  logic                         horz,
  input  logic [VID_AW-1:0]            ppu_addr,
  output logic [CHR_BANK_W+VID_AW-1:0] chr_rom_addr,
  output logic [mapper_pkg::NT_PAGE_AW:0] nt_ram_addr
);
  localparam int PW = mapper_pkg::NT_PAGE_AW;

  function automatic logic [PW:0] fold(input logic [VID_AW-1:0] a, input logic h);
    logic page;
    page = h ? a[PW+1] : a[PW];
    return {page, a[PW-1:0]};
  endfunction

  assign chr_rom_addr = {chr_bank, ppu_addr};
  assign nt_ram_addr  = fold(ppu_addr, horz);
endmodule

// File: rtl/addr_latch_mapper.sv
module addr_latch_mapper #(
  parameter int PRG_BANK_W = 6,
  parameter int CHR_BANK_W = 6,
  parameter int PRG_CHUNKS = 64,
  parameter int VID_AW     = 13
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cpu_cs,
  input  logic                              cpu_we,
  input  logic [15:0]                       cpu_addr,
  input  logic [VID_AW-1:0]                 ppu_addr,
  output logic [PRG_BANK_W+13:0]            prg_rom_addr,
  output logic [CHR_BANK_W+VID_AW-1:0]      chr_rom_addr,
  output logic [mapper_pkg::NT_PAGE_AW:0]   nt_ram_addr,
  output logic                              mirror_horz
);
  import mapper_pkg::*;

  logic                  wr_hit;
  logic [CHR_BANK_W-1:0] chr_bank;
  logic [PRG_BANK_W-1:0] prg_num;
  logic                  mode16;
  mirror_e               mirror;
  logic [PRG_BANK_W-1:0] win_bank [2];
  logic [PRG_BANK_W-1:0] lo_bank, hi_bank;

  assign wr_hit = cpu_cs & cpu_we & cpu_addr[GATE_BIT];

  mapper_cfg_reg #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W),
                   .PRG_CHUNKS(PRG_CHUNKS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .wr_addr(cpu_addr),
    .chr_bank(chr_bank), .prg_num(prg_num), .mode16(mode16), .mirror(mirror)
  );

  for (genvar w = 0; w < 2; w++) begin : g_win
    prg_window_map #(.W(PRG_BANK_W), .UPPER(w)) u_win (
      .num(prg_num), .mode16(mode16), .bank(win_bank[w])
    );
  end

  assign lo_bank      = win_bank[0];
  assign hi_bank      = win_bank[1];
  assign prg_rom_addr = {(cpu_addr[WIN_SEL] ? hi_bank : lo_bank), cpu_addr[13:0]};
  assign mirror_horz  = (mirror == MIR_HORZ);

  chr_nt_map #(.CHR_BANK_W(CHR_BANK_W), .VID_AW(VID_AW)) u_vid (
    .chr_bank(chr_bank), .horz(mirror_horz), .ppu_addr(ppu_addr),
    .chr_rom_addr(chr_rom_addr), .nt_ram_addr(nt_ram_addr)
  );
endmodule

// File: rtl/mapper_props.sv
module mapper_props #(
  parameter int PRG_BANK_W = 6,
  parameter int CHR_BANK_W = 6,
  parameter int PRG_CHUNKS = 64,
  parameter int VID_AW     = 13
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_hit,
  input logic [15:0]                   cpu_addr,
  input logic [VID_AW-1:0]             ppu_addr,
  input logic [PRG_BANK_W+13:0]        prg_rom_addr,
  input logic [CHR_BANK_W+VID_AW-1:0]  chr_rom_addr,
  input logic [10:0]                   nt_ram_addr,
  input logic [PRG_BANK_W-1:0]         lo_bank,
  input logic [PRG_BANK_W-1:0]         hi_bank,
  input logic [CHR_BANK_W-1:0]         chr_bank,
  input logic                          mirror_horz
);
  localparam logic [PRG_BANK_W-1:0] RST_CHUNK = PRG_BANK_W'(PRG_CHUNKS - 2);

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(lo_bank) && $stable(hi_bank) && $stable(chr_bank) && $stable(mirror_horz))); // R1
  AST_CHR_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> chr_bank == $past(cpu_addr[5:0])); // R2
  AST_PAIR_32K: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !cpu_addr[12]) |=> (lo_bank == {$past(cpu_addr[11:7]), 1'b0} &&
                                   hi_bank == {$past(cpu_addr[11:7]), 1'b1})); // R3
  AST_SAME_16K: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && cpu_addr[12]) |=> (lo_bank == $past(cpu_addr[11:6]) && hi_bank == lo_bank)); // R4
  AST_PRG_COMPOSE: assert property (@(posedge clk) disable iff (!rst_n)
    prg_rom_addr == {(cpu_addr[14] ? hi_bank : lo_bank), cpu_addr[13:0]}); // R5
  AST_MIRROR_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> mirror_horz == $past(cpu_addr[13])); // R6
  AST_NT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_ram_addr[9:0] == ppu_addr[9:0]) &&
    (nt_ram_addr[10] == (mirror_horz ? ppu_addr[11] : ppu_addr[10]))); // R7
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (lo_bank == RST_CHUNK && hi_bank == RST_CHUNK && chr_bank == '0 && !mirror_horz)); // R8
endmodule

bind addr_latch_mapper mapper_props #(
  .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W),
  .PRG_CHUNKS(PRG_CHUNKS), .VID_AW(VID_AW)
) u_props (.*);

// File: tb/sim_addr_latch_mapper.sv
`timescale 1ns/100ps
module sim_addr_latch_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_cs = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [12:0] ppu_addr = 13'h0;
  logic [19:0] prg_rom_addr;
  logic [18:0] chr_rom_addr;
  logic [10:0] nt_ram_addr;
  logic        mirror_horz;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_lo, exp_hi, exp_chr, exp_h;

  always #2 clk = ~clk;

  addr_latch_mapper u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model update from a write address, by arithmetic on the field values.
  task automatic model_write(input int a);
    int num;
    num = (a / 64) % 64;
    exp_chr = a % 64;
    exp_h   = (a / 8192) % 2;
    if ((a / 4096) % 2 == 1) begin exp_lo = num; exp_hi = num; end
    else begin exp_lo = (num / 2) * 2; exp_hi = exp_lo + 1; end
  endtask

  // Probe all mappings during the low clock phase.
  task automatic probe(input string req, input int seed);
    int off, p, pg;
    off = (seed * 1237 + 5) % 16384;
    p   = (seed * 2731 + 11) % 8192;
    cpu_addr = 16'(32768 + off); #0.2;
    check({req, " lo window"}, int'(prg_rom_addr), exp_lo * 16384 + off);
    cpu_addr = 16'(49152 + off); #0.2;
    check({req, " hi window"}, int'(prg_rom_addr), exp_hi * 16384 + off);
    ppu_addr = 13'(p); #0.2;
    check({req, " R2 chr"}, int'(chr_rom_addr), exp_chr * 8192 + p);
    pg = exp_h ? (p / 2048) % 2 : (p / 1024) % 2;
    check({req, " R7 nt"}, int'(nt_ram_addr), pg * 1024 + p % 1024);
    check({req, " R6 mirror"}, int'(mirror_horz), exp_h);
  endtask

  task automatic bus_write(input int a, input logic cs, input logic we);
    @(negedge clk);
    cpu_cs = cs; cpu_we = we; cpu_addr = 16'(a);
    @(negedge clk);
    cpu_cs = 1'b0; cpu_we = 1'b0;
    if (cs && we && a >= 32768) model_write(a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    exp_lo = 62; exp_hi = 62; exp_chr = 0; exp_h = 0;
    probe("R8 reset", 1);
    rst_n = 1'b1;
    @(negedge clk);
    probe("R8 after release", 2);

    // R3 / R4 / R5: every bank number in both program modes.
    for (int m = 0; m < 2; m++)
      for (int n = 0; n < 64; n++) begin
        bus_write(32768 + m * 4096 + n * 64 + (n % 64), 1'b1, 1'b1);
        probe(m ? "R4 16K R5" : "R3 32K R5", n + m * 64);
      end

    // R2 / R6 / R7: every character bank under both mirrorings.
    for (int h = 0; h < 2; h++)
      for (int c = 0; c < 64; c++) begin
        bus_write(32768 + h * 8192 + 4096 + ((c * 7) % 64) * 64 + c, 1'b1, 1'b1);
        probe("R2 R6 R7 sweep", c + h * 64 + 200);
      end

    // R1: non-loading cycles leave everything as it was.
    bus_write(16'hD2C5, 1'b1, 1'b1);
    probe("R1 base", 400);
    bus_write(16'hFFFF, 1'b1, 1'b0);
    probe("R1 read", 401);
    bus_write(16'h7FFF, 1'b1, 1'b1);
    probe("R1 low write", 402);
    bus_write(16'hEFC0, 1'b0, 1'b1);
    probe("R1 no select", 403);

    // R9: back-to-back writes, checked between them.
    @(negedge clk);
    cpu_cs = 1; cpu_we = 1; cpu_addr = 16'hA02A;
    @(negedge clk);
    model_write(16'hA02A);
    check("R9 first write chr", int'(chr_rom_addr[18:13]), exp_chr);
    check("R9 first write mirror", int'(mirror_horz), exp_h);
    cpu_addr = 16'h9015;
    @(negedge clk);
    cpu_cs = 0; cpu_we = 0;
    model_write(16'h9015);
    probe("R9 second write", 500);

    // R8 again: reset mid-run restores defaults.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_lo = 62; exp_hi = 62; exp_chr = 0; exp_h = 0;
    probe("R8 re-reset", 600);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule